// File: doc/BRIEF.md
# Set-Associative Cache Controller

The block sits between a processor that issues single-word reads and writes and a slower main memory that moves one word per handshake. Its storage is organized as a number of sets, each with several ways. A way holds a line of adjacent words, a stored tag, a valid flag and, in write-back builds, a dirty flag. The processor word address is split into three fields. The low field picks the word within a line, the middle field picks the set, and the rest is the tag. The request tag is compared against every way of the selected set in parallel. A hit is served in the cycle the request is presented.

On a miss the controller picks a victim way. An empty way is always taken first. When the set is full, the victim is chosen by a compile-time policy: least-recently-used or first-in-first-out. A dirty victim is copied out to main memory before the new line is read in. A second compile-time choice sets the write policy. In write-through mode every processor write goes to main memory and the processor waits for it. In write-back mode, writes stay in the cache until the line is evicted.

The processor must hold its request (address, direction, write data) steady from the cycle `cpu_valid` rises until the cycle in which `cpu_ready` is high. The request completes in that cycle.

Top module: `sa_cache`

## Requirements
- R1: The word address splits as offset = bits [OFF_W-1:0], set index = the next IDX_W bits, tag = the remaining upper bits (OFF_W = log2 of words per line, IDX_W = log2 of sets). Every line transfer on the memory side moves the words at offsets 0, 1, ... up to the last offset, in that order, with the upper address bits held.
- R2: A read that hits completes in the same cycle it is presented (`cpu_ready` high while `cpu_valid` is high) and returns the stored word. `cpu_ready` is never high without `cpu_valid`.
- R3: A read miss to a clean or empty victim reads the whole line from main memory, one word per `mem_valid`/`mem_ready` handshake with `mem_we` low. It then completes with the memory word. With memory that is ready at once, the request completes after 1 + LINE_WORDS stalled cycles.
- R4: If the selected set has a way whose valid flag is clear, the lowest-numbered such way is filled. The lines already present in the set stay resident.
- R5: In LRU builds, a miss in a full set replaces the way whose last hit or fill is the oldest in that set.
- R6: In FIFO builds, a miss in a full set replaces the way that was filled earliest. Hits do not change that order.
- R7: In write-back builds, a write hit completes in the cycle it is presented, updates the cached word, marks the line dirty and leaves main memory unchanged.
- R8: In write-back builds, a miss whose victim is dirty first writes the victim's words to main memory with `mem_we` high, then fills the new line. With zero-wait memory, the request completes after 1 + 2*LINE_WORDS stalled cycles.
- R9: In write-back builds, a write miss allocates the line, merges the written word into it, and completes once the fill is done.
- R10: In write-through builds, every write issues one word write to main memory at the request address. The request completes in the cycle after that handshake, which is 2 stalled cycles with zero-wait memory. A write hit also updates the cached copy.
- R11: In write-through builds, a write miss does not allocate a line, so a later read of that address misses.
- R12: Reset clears every valid and dirty flag. In the cycle after reset, `mem_valid` and `cpu_ready` are low, and the first access to any address misses.
- R13: While `mem_valid` is high and `mem_ready` is low, the memory request is held steady. Results are correct for any pattern of memory stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_valid | output | 1 | Main-memory word request present |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | ADDR_W | Main-memory word address |
| mem_wdata | output | DATA_W | Word written to main memory |
| mem_ready | input | 1 | Memory accepts the word this cycle; read data valid |
| mem_rdata | input | DATA_W | Word read from main memory |

## Verification
The results are due at these points, counted in stalled cycles (cycles with `cpu_valid` high and `cpu_ready` low) from when the request is presented, with zero-wait memory:
- read or write-back write hit: 0 cycles;
- clean miss: 1 + LINE_WORDS cycles;
- dirty miss: 1 + 2*LINE_WORDS cycles;
- write-through write: 2 cycles.

The driver puts each expected word and latency in a queue. A monitor counts stalled cycles at falling edges and compares the count, and the word on `cpu_rdata`, at the falling edge where `cpu_ready` is high. Main-memory contents are compared only after a request has completed, so deferred and immediate memory updates are seen at defined points. A final phase lets memory stall in a rotating pattern and checks data only, since latency then depends on the stall pattern.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic {
        REPL_LRU,
        REPL_FIFO
    } repl_e;

    typedef enum logic {
        WP_THROUGH,
        WP_BACK
    } wpol_e;

    typedef enum logic [2:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WT_REQ,
        ST_WT_DONE
    } state_e;

    function automatic int unsigned sel_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 6,
    parameter int unsigned WAY_W = 1
) (
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
    input  logic [WAYS-1:0]             way_valid,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tags[g] == req_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_repl.sv
module cache_repl #(
    parameter int unsigned        WAYS   = 2,
    parameter int unsigned        SETS   = 4,
    parameter cache_pkg::repl_e   POLICY = cache_pkg::REPL_LRU,
    localparam int unsigned       IDX_W  = cache_pkg::sel_width(SETS),
    localparam int unsigned       WAY_W  = cache_pkg::sel_width(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [WAYS-1:0]   set_valid,
    input  logic              touch_en,
    input  logic [WAY_W-1:0]  touch_way,
    input  logic              fill_en,
    output logic [WAY_W-1:0]  victim_way
);

    logic [WAY_W-1:0] pol_way;

    if (POLICY == cache_pkg::REPL_LRU) begin : g_lru
        // age 0 = most recent; ages in a set are always a permutation
        logic [WAY_W-1:0] age_q [SETS][WAYS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= WAY_W'(w);
            end else if (touch_en || fill_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[set_idx][w] <= '0;
                    else if (age_q[set_idx][w] < age_q[set_idx][touch_way])
                        age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
                end
            end
        end

        always_comb begin
            pol_way = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) pol_way = WAY_W'(w);
            end
        end
    end else begin : g_fifo
        logic [WAY_W-1:0] ptr_q [SETS];
        logic             unused_touch;

        assign unused_touch = touch_en ^ (|touch_way);

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
            end else if (fill_en) begin
                if (ptr_q[set_idx] == WAY_W'(WAYS - 1))
                    ptr_q[set_idx] <= '0;
                else
                    ptr_q[set_idx] <= ptr_q[set_idx] + 1'b1;
            end
        end

        assign pol_way = ptr_q[set_idx];
    end

    // an empty way always wins; the lowest-numbered one first
    always_comb begin
        victim_way = pol_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) victim_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/sa_cache.sv
module sa_cache #(
    parameter int unsigned       ADDR_W     = 10,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       WAYS       = 2,
    parameter int unsigned       SETS       = 4,
    parameter int unsigned       LINE_WORDS = 4,
    parameter cache_pkg::repl_e  REPL       = cache_pkg::REPL_LRU,
    parameter cache_pkg::wpol_e  WPOL       = cache_pkg::WP_BACK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    import cache_pkg::*;

    localparam int unsigned OFF_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned WAY_W = sel_width(WAYS);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);
    localparam bit WB = (WPOL == WP_BACK);

    // storage
    logic              v_q    [SETS][WAYS];
    logic              d_q    [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS][LINE_WORDS];

    // request fields
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;

    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    // selected set
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w]  = tag_q[req_idx][w];
            set_valid[w] = v_q[req_idx][w];
        end
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;

    cache_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .req_tag   (req_tag),
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    // control state
    state_e           state_q, state_d;
    logic [OFF_W-1:0] cnt_q, cnt_d;
    logic [WAY_W-1:0] vic_q, vic_d;

    logic cpu_wr;      // merge processor word into hit line
    logic fill_word;   // store one fetched word
    logic install;     // last fill word: line becomes valid
    logic touch_en;
    logic [WAY_W-1:0] touch_way;

    cache_repl #(
        .WAYS   (WAYS),
        .SETS   (SETS),
        .POLICY (REPL)
    ) u_repl (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (req_idx),
        .set_valid  (set_valid),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .fill_en    (install),
        .victim_way (victim_way)
    );

    assign cpu_rdata = data_q[req_idx][hit_way][req_off];
    assign touch_way = (state_q == ST_FILL) ? vic_q : hit_way;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        vic_d     = vic_q;
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cpu_wr    = 1'b0;
        fill_word = 1'b0;
        install   = 1'b0;
        touch_en  = 1'b0;

        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_valid) begin
                    if (cpu_we && !WB) begin
                        state_d = ST_WT_REQ;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                        cpu_wr    = cpu_we;
                        touch_en  = 1'b1;
                    end else begin
                        vic_d = victim_way;
                        cnt_d = '0;
                        if (WB && v_q[req_idx][victim_way] && d_q[req_idx][victim_way])
                            state_d = ST_EVICT;
                        else
                            state_d = ST_FILL;
                    end
                end
            end

            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[req_idx][vic_q], req_idx, cnt_q};
                mem_wdata = data_q[req_idx][vic_q][cnt_q];
                if (mem_ready) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_OFF) state_d = ST_FILL;
                end
            end

            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, req_idx, cnt_q};
                if (mem_ready) begin
                    fill_word = 1'b1;
                    cnt_d     = cnt_q + 1'b1;
                    if (cnt_q == LAST_OFF) begin
                        install = 1'b1;
                        state_d = ST_LOOKUP;
                    end
                end
            end

            ST_WT_REQ: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
                if (mem_ready) state_d = ST_WT_DONE;
            end

            ST_WT_DONE: begin
                cpu_ready = 1'b1;
                cpu_wr    = hit;
                touch_en  = hit;
                state_d   = ST_LOOKUP;
            end

            default: state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
            vic_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vic_q   <= vic_d;
        end
    end

    // flags
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    v_q[s][w] <= 1'b0;
                    d_q[s][w] <= 1'b0;
                end
            end
        end else begin
            if (install) begin
                v_q[req_idx][vic_q] <= 1'b1;
                d_q[req_idx][vic_q] <= 1'b0;
            end
            if (cpu_wr && WB) d_q[req_idx][hit_way] <= 1'b1;
        end
    end

    // tags and data
    always_ff @(posedge clk) begin
        if (cpu_wr)    data_q[req_idx][hit_way][req_off] <= cpu_wdata;
        if (fill_word) data_q[req_idx][vic_q][cnt_q]     <= mem_rdata;
        if (install)   tag_q[req_idx][vic_q]             <= req_tag;
    end

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
    parameter int unsigned      ADDR_W     = 10,
    parameter int unsigned      DATA_W     = 32,
    parameter int unsigned      LINE_WORDS = 4,
    parameter cache_pkg::wpol_e WPOL       = cache_pkg::WP_BACK
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);

    localparam int unsigned OFF_W = $clog2(LINE_WORDS);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

    logic line_beat;
    assign line_beat = mem_valid && mem_ready &&
                       ((WPOL == cache_pkg::WP_BACK) || !mem_we) &&
                       (mem_addr[OFF_W-1:0] != LAST_OFF);

    AST_LINE_ORDER: assert property (@(posedge clk) disable iff (rst)
        line_beat |=> mem_valid &&
                      mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1) &&
                      mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])); // R1

    AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_valid); // R2

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_valid && !cpu_ready); // R12

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_we) && $stable(mem_wdata)); // R13

    if (WPOL == cache_pkg::WP_BACK) begin : g_wb
        AST_WB_WRITE_LOCAL: assert property (@(posedge clk) disable iff (rst)
            cpu_valid && cpu_ready && cpu_we |-> !mem_valid); // R7
    end else begin : g_wt
        AST_WT_WRITE_MEM: assert property (@(posedge clk) disable iff (rst)
            cpu_valid && cpu_ready && cpu_we |-> $past(mem_valid && mem_ready && mem_we)); // R10
    end

endmodule

bind sa_cache cache_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS),
    .WPOL       (WPOL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sa_cache_tb.sv
module sa_cache_tb;
    import cache_pkg::*;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // index 0: LRU + write-back, index 1: FIFO + write-through
    logic          cpu_valid [2];
    logic          cpu_we    [2];
    logic [AW-1:0] cpu_addr  [2];
    logic [DW-1:0] cpu_wdata [2];
    logic          cpu_ready [2];
    logic [DW-1:0] cpu_rdata [2];
    logic          mem_valid [2];
    logic          mem_we    [2];
    logic [AW-1:0] mem_addr  [2];
    logic [DW-1:0] mem_wdata [2];
    logic          mem_ready [2];
    logic [DW-1:0] mem_rdata [2];

    for (genvar g = 0; g < 2; g++) begin : g_dut
        sa_cache #(
            .ADDR_W (AW),
            .DATA_W (DW),
            .REPL   (g == 0 ? REPL_LRU : REPL_FIFO),
            .WPOL   (g == 0 ? WP_BACK : WP_THROUGH)
        ) u_dut (
            .clk       (clk),
            .rst       (rst),
            .cpu_valid (cpu_valid[g]),
            .cpu_we    (cpu_we[g]),
            .cpu_addr  (cpu_addr[g]),
            .cpu_wdata (cpu_wdata[g]),
            .cpu_ready (cpu_ready[g]),
            .cpu_rdata (cpu_rdata[g]),
            .mem_valid (mem_valid[g]),
            .mem_we    (mem_we[g]),
            .mem_addr  (mem_addr[g]),
            .mem_wdata (mem_wdata[g]),
            .mem_ready (mem_ready[g]),
            .mem_rdata (mem_rdata[g])
        );
    end

    function automatic logic [DW-1:0] pat(input int a);
        return 32'h5A00_0000 | 32'(a);
    endfunction

    // main memory model
    logic [DW-1:0] mem_model [2][MEMSZ];
    logic [DW-1:0] ref_mem   [2][MEMSZ];
    bit            stall_en = 1'b0;
    int unsigned   cyc = 0;

    always_comb begin
        for (int d = 0; d < 2; d++) begin
            mem_ready[d] = mem_valid[d] && (!stall_en || (((cyc + d) % 3) == 2));
            mem_rdata[d] = mem_model[d][mem_addr[d]];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < MEMSZ; a++)
                    mem_model[d][a] <= pat(a);
        end else begin
            for (int d = 0; d < 2; d++)
                if (mem_valid[d] && mem_ready[d] && mem_we[d])
                    mem_model[d][mem_addr[d]] <= mem_wdata[d];
        end
    end

    // counters and check
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string msg,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        int            d;
        bit            we;
        logic [DW-1:0] exp;
        int            lat;
        string         msg;
    } item_t;

    item_t sb_q[$];
    item_t it;
    int    lat_cnt [2] = '{0, 0};

    always @(negedge clk) begin
        if (!rst) begin
            for (int d = 0; d < 2; d++) begin
                if (cpu_valid[d]) begin
                    if (cpu_ready[d]) begin
                        if (sb_q.size() == 0) begin
                            chk(1'b0, "R2 completion with empty scoreboard", 32'(d), 0);
                        end else begin
                            it = sb_q.pop_front();
                            chk(it.d == d, {it.msg, " port"}, 32'(d), 32'(it.d));
                            if (!it.we)
                                chk(cpu_rdata[d] == it.exp, {it.msg, " data"}, cpu_rdata[d], it.exp);
                            if (it.lat >= 0)
                                chk(lat_cnt[d] == it.lat, {it.msg, " latency"}, 32'(lat_cnt[d]), 32'(it.lat));
                        end
                        lat_cnt[d] = 0;
                    end else begin
                        lat_cnt[d] = lat_cnt[d] + 1;
                    end
                end
            end
        end
    end

    task automatic cpu_op(input int d, input bit we, input int a,
                          input logic [DW-1:0] wd, input int lat, input string msg);
        item_t ni;
        ni.d   = d;
        ni.we  = we;
        ni.exp = we ? wd : ref_mem[d][a];
        ni.lat = lat;
        ni.msg = msg;
        sb_q.push_back(ni);
        if (we) ref_mem[d][a] = wd;
        @(posedge clk); #1;
        cpu_valid[d] = 1'b1;
        cpu_we[d]    = we;
        cpu_addr[d]  = AW'(a);
        cpu_wdata[d] = wd;
        forever begin
            @(negedge clk);
            if (cpu_ready[d]) break;
        end
        @(posedge clk); #1;
        cpu_valid[d] = 1'b0;
        cpu_we[d]    = 1'b0;
    endtask

    task automatic chk_mem(input int d, input int a, input logic [DW-1:0] exp,
                           input string msg);
        chk(mem_model[d][a] == exp, msg, mem_model[d][a], exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // set-0 lines: tag = addr >> 4
    localparam int LA = 'h000;
    localparam int LB = 'h010;
    localparam int LC = 'h020;
    localparam int LD = 'h030;
    localparam int LE = 'h0A4;   // set 1

    initial begin
        for (int d = 0; d < 2; d++) begin
            cpu_valid[d] = 1'b0;
            cpu_we[d]    = 1'b0;
            cpu_addr[d]  = '0;
            cpu_wdata[d] = '0;
            for (int a = 0; a < MEMSZ; a++) ref_mem[d][a] = pat(a);
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(!cpu_ready[d], "R12 cpu_ready low after reset", 32'(cpu_ready[d]), 0);
            chk(!mem_valid[d], "R12 mem_valid low after reset", 32'(mem_valid[d]), 0);
        end

        // ---------- LRU + write-back ----------
        cpu_op(0, 0, LA + 1, 0, 5, "R12 R3 first read misses");
        cpu_op(0, 0, LA + 2, 0, 0, "R2 read hit");
        cpu_op(0, 1, LA + 1, 32'hDEAD_0001, 0, "R7 write hit");
        chk_mem(0, LA + 1, pat(LA + 1), "R7 memory unchanged after write hit");
        cpu_op(0, 0, LA + 1, 0, 0, "R7 read back written word");
        cpu_op(0, 0, LB, 0, 5, "R4 fill empty way");
        cpu_op(0, 0, LA, 0, 0, "R4 first line still resident");
        cpu_op(0, 0, LC, 0, 5, "R5 miss replaces oldest");
        cpu_op(0, 0, LA, 0, 0, "R5 recently used line kept");
        cpu_op(0, 0, LB, 0, 5, "R5 evicted line misses");
        cpu_op(0, 0, LC, 0, 9, "R8 dirty victim written back");
        chk_mem(0, LA + 1, 32'hDEAD_0001, "R8 memory holds evicted word");
        chk_mem(0, LA + 2, pat(LA + 2), "R8 memory clean word kept");
        cpu_op(0, 1, LD, 32'hBEEF_0003, 5, "R9 write miss allocates");
        cpu_op(0, 0, LD, 0, 0, "R9 allocated line hits");
        chk_mem(0, LD, pat(LD), "R9 memory untouched by allocated write");
        cpu_op(0, 0, LA + 1, 0, 5, "R8 refetch of written-back word");

        // ---------- FIFO + write-through ----------
        cpu_op(1, 0, LA, 0, 5, "R12 R3 first read misses (fifo)");
        cpu_op(1, 0, LB, 0, 5, "R4 fill empty way (fifo)");
        cpu_op(1, 0, LA, 0, 0, "R6 hit does not reorder");
        cpu_op(1, 0, LC, 0, 5, "R6 miss replaces earliest fill");
        cpu_op(1, 0, LB, 0, 0, "R6 later fill kept");
        cpu_op(1, 0, LA, 0, 5, "R6 earliest line was evicted");
        cpu_op(1, 0, LC, 0, 0, "R6 queue order kept");
        cpu_op(1, 1, LA + 3, 32'hCAFE_0007, 2, "R10 write-through hit");
        chk_mem(1, LA + 3, 32'hCAFE_0007, "R10 memory written at once");
        cpu_op(1, 0, LA + 3, 0, 0, "R10 cached copy updated");
        cpu_op(1, 1, LE, 32'hF00D_0009, 2, "R11 write-through miss");
        chk_mem(1, LE, 32'hF00D_0009, "R11 memory written on miss");
        cpu_op(1, 0, LE, 0, 5, "R11 no allocation on write miss");

        // ---------- memory stalls, data only ----------
        stall_en = 1'b1;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                int a;
                a = (i * 37 + 5) % MEMSZ;
                if (i % 3 == 0)
                    cpu_op(d, 1, a, 32'h1000_0000 + 32'(i), -1, "R13 write under stall");
                else
                    cpu_op(d, 0, a, 0, -1, "R13 read under stall");
            end
            for (int i = 0; i < 16; i++) begin
                cpu_op(d, 0, (i * 37 + 5) % MEMSZ, 0, -1, "R13 read back under stall");
            end
        end

        chk(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule